// File: doc/BRIEF.md
# Reset Source Capture and Stretcher

This block drives the active-low, bidirectional system reset line of a controller. Several things can ask for a reset: a list of internal request strobes, the supply first coming up, and any outside circuit that pulls the line low. Whatever the cause, the block holds the line low for a whole number of millisecond ticks. It records which source started the pulse in a status code that software can read.

By default every pulse is long. Software can choose a short pulse by writing a control bit. The bit returns to long on its own when the supply first comes up, when an outside agent pulls the line low, and when the restart mode is entered. If a pulse was shortened by mistake, the controller therefore gets a long pulse on its next attempt at the latest.

Power-on and an outside pull share one source code. A separate power-on flag tells them apart. The status stays in place until software clears it with a read-to-clear strobe.

Top module: `reset_capture_stretch`

## Requirements
- R1: After the block's own reset, `pullLow` is 0, `statusCode` is 0 (no reset recorded), `porFlag` is 0 and `shortLenQ` is 0 (long length).
- R2: With no pulse running and `porActive` low, a request on any `srcReq` bit drives `pullLow` high from the next cycle on. While the short bit is 0, the line is released in the cycle after the `LONG_MS`-th `tick` that follows the start. It is never released in a cycle that has no tick.
- R3: While `shortLenQ` is 1, a pulse started by a `srcReq` request lasts `SHORT_MS` ticks.
- R4: A `cfgWr` strobe loads `cfgShort` into `shortLenQ` on the next cycle (1 = short, 0 = long), unless a clearing event happens in the same cycle.
- R5: While `porActive` is high, `pullLow` is held high and ticks are not counted. Each such cycle sets `porFlag` to 1, sets `statusCode` to 1 and clears `shortLenQ`. After `porActive` falls, the pulse lasts `LONG_MS` ticks.
- R6: A falling edge of `padIn` that the block did not cause starts a pulse with `statusCode` 1. It leaves `porFlag` unchanged, clears `shortLenQ` and always uses the long length.
- R7: A `restartEntry` strobe sets `shortLenQ` to 0 on the next cycle.
- R8: `srcReq[k]` records code k+2. When several sources fire in the same cycle, the lowest-numbered one is recorded. An outside falling edge ranks above every `srcReq` bit.
- R9: Requests that arrive while a pulse is running neither restart the count nor change `statusCode`.
- R10: `statusCode` and `porFlag` keep their values until `rdClr`, which zeroes both on the next cycle. If a pulse starts in the same cycle as `rdClr`, the new code is kept.
- R11: `resetActive` is high whenever the block pulls the line low or `padIn` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's own registers |
| srcReq | input | NUM_REQ | One reset request strobe per internal source |
| porActive | input | 1 | High while the supply has not yet come up after first connection |
| padIn | input | 1 | Synchronised level of the reset line |
| tick | input | 1 | One-cycle strobe every millisecond |
| cfgWr | input | 1 | Write strobe for the short-length bit |
| cfgShort | input | 1 | Value written to the short-length bit |
| restartEntry | input | 1 | Strobe on entry to restart mode |
| rdClr | input | 1 | Read-to-clear strobe for the status |
| pullLow | output | 1 | Enable for the pad pull-down |
| resetActive | output | 1 | High while the reset line is low from any driver |
| statusCode | output | CODE_W | Code of the source that started the last pulse, 0 when none |
| porFlag | output | 1 | Set by a power-on reset only |
| shortLenQ | output | 1 | Current short-length setting |

## Verification
The hardest case to reach is an outside falling edge. It must be told apart from the block's own pull on the same wire, and it must win over a short setting made just before. The bench models the line as a wired-AND of the block's pull and an outside driver. It sets the short bit, then lowers the outside driver while the line is idle, and measures the long pulse that follows. The bench also sweeps every non-zero mix of simultaneous requests, so the priority result can be checked against the lowest set index.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int NUM_REQ = 8;
  localparam int CODE_W  = $clog2(NUM_REQ + 2);
  localparam logic [CODE_W-1:0] CODE_NONE    = '0;
  localparam logic [CODE_W-1:0] CODE_PWR_EXT = CODE_W'(1);

  typedef struct packed {
    logic              load;
    logic              useLong;
    logic              dec;
    logic              capture;
    logic              porSet;
    logic              clear;
    logic [CODE_W-1:0] code;
  } strobe_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] srcReq,
  input  logic               porActive,
  input  logic               padIn,
  input  logic               tick,
  input  logic               cfgWr,
  input  logic               cfgShort,
  input  logic               restartEntry,
  input  logic               rdClr,
  input  logic               cntIsOne,
  output strobe_t            strb,
  output logic               stretching,
  output logic               shortLen
);
  logic padPrev;
  logic extEdge;
  logic start;
  logic [CODE_W-1:0] reqCode;

  // Outside falling edge: only counted when the block itself is not pulling.
  assign extEdge = padPrev && !padIn && !stretching && !porActive;
  assign start   = !stretching && !porActive && (extEdge || (|srcReq));

  // Fixed priority: lowest index wins, outside edge ranks above all requests.
  always_comb begin
    reqCode = CODE_NONE;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      if (srcReq[k]) reqCode = CODE_W'(k + 2);
    end
    if (extEdge) reqCode = CODE_PWR_EXT;
  end

  always_comb begin
    strb.load    = porActive || start;
    strb.useLong = porActive || extEdge || !shortLen;
    strb.dec     = stretching && !porActive && tick;
    strb.capture = porActive || start;
    strb.porSet  = porActive;
    strb.clear   = rdClr;
    strb.code    = porActive ? CODE_PWR_EXT : reqCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padPrev    <= 1'b1;
      stretching <= 1'b0;
      shortLen   <= 1'b0;
    end else begin
      padPrev <= padIn;
      if (porActive || start)          stretching <= 1'b1;
      else if (strb.dec && cntIsOne)   stretching <= 1'b0;
      if (porActive || restartEntry || extEdge) shortLen <= 1'b0;
      else if (cfgWr)                           shortLen <= cfgShort;
    end
  end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int LONG_MS  = 20,
  parameter int SHORT_MS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic              cntIsOne,
  output logic [CODE_W-1:0] statusCode,
  output logic              porFlag
);
  localparam int CNT_W = $clog2(LONG_MS + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_MS);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_MS);

  logic [CNT_W-1:0] cnt;

  assign cntIsOne = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      statusCode <= CODE_NONE;
      porFlag    <= 1'b0;
    end else begin
      if (strb.load)     cnt <= strb.useLong ? LONG_LD : SHORT_LD;
      else if (strb.dec) cnt <= cnt - CNT_W'(1);
      if (strb.capture)    statusCode <= strb.code;
      else if (strb.clear) statusCode <= CODE_NONE;
      if (strb.porSet)     porFlag <= 1'b1;
      else if (strb.clear) porFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/reset_capture_stretch.sv
module reset_capture_stretch
  import rcs_pkg::*;
#(
  parameter int LONG_MS  = 20,
  parameter int SHORT_MS = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] srcReq,
  input  logic               porActive,
  input  logic               padIn,
  input  logic               tick,
  input  logic               cfgWr,
  input  logic               cfgShort,
  input  logic               restartEntry,
  input  logic               rdClr,
  output logic               pullLow,
  output logic               resetActive,
  output logic [CODE_W-1:0]  statusCode,
  output logic               porFlag,
  output logic               shortLenQ
);
  strobe_t strb;
  logic    cntIsOne;
  logic    stretching;

  rcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .porActive(porActive),
    .padIn(padIn), .tick(tick), .cfgWr(cfgWr), .cfgShort(cfgShort),
    .restartEntry(restartEntry), .rdClr(rdClr), .cntIsOne(cntIsOne),
    .strb(strb), .stretching(stretching), .shortLen(shortLenQ)
  );

  rcs_datapath #(.LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntIsOne(cntIsOne),
    .statusCode(statusCode), .porFlag(porFlag)
  );

  assign pullLow     = stretching;
  assign resetActive = stretching || !padIn;
endmodule

// File: rtl/reset_capture_stretch_chk.sv
module reset_capture_stretch_chk
  import rcs_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] srcReq,
  input logic               porActive,
  input logic               tick,
  input logic               rdClr,
  input logic               restartEntry,
  input logic               pullLow,
  input logic [CODE_W-1:0]  statusCode,
  input logic               shortLenQ
);
  // R2
  req_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pullLow && (|srcReq) && !porActive) |=> pullLow);

  // R2
  no_release_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullLow && !tick) |=> pullLow);

  // R5
  por_holds_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    porActive |=> pullLow);

  // R9
  code_steady_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullLow && !porActive && !rdClr) |=> $stable(statusCode));

  // R7
  restart_reverts_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartEntry |=> !shortLenQ);
endmodule

bind reset_capture_stretch reset_capture_stretch_chk chk_i (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .porActive(porActive),
  .tick(tick), .rdClr(rdClr), .restartEntry(restartEntry),
  .pullLow(pullLow), .statusCode(statusCode), .shortLenQ(shortLenQ)
);

// File: tb/reset_capture_stretch_tb_top.sv
module reset_capture_stretch_tb_top;
  import rcs_pkg::*;
  localparam int LONG_N  = 4;
  localparam int SHORT_N = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_REQ-1:0] srcReq = '0;
  logic porActive = 1'b0, tick = 1'b0, cfgWr = 1'b0, cfgShort = 1'b0;
  logic restartEntry = 1'b0, rdClr = 1'b0, extLow = 1'b0;
  logic pullLow, resetActive, porFlag, shortLenQ;
  logic [CODE_W-1:0] statusCode;
  logic padIn;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  assign padIn = !(pullLow || extLow);

  always #5 clk = !clk;

  reset_capture_stretch #(.LONG_MS(LONG_N), .SHORT_MS(SHORT_N)) dut_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .porActive(porActive),
    .padIn(padIn), .tick(tick), .cfgWr(cfgWr), .cfgShort(cfgShort),
    .restartEntry(restartEntry), .rdClr(rdClr), .pullLow(pullLow),
    .resetActive(resetActive), .statusCode(statusCode), .porFlag(porFlag),
    .shortLenQ(shortLenQ)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Runs a pulse already started: n ticks, each preceded by an idle cycle.
  task automatic runPulse(input int n, input string tag);
    for (int t = 1; t <= n; t++) begin
      step();
      chk({tag, " held without tick"}, pullLow, 1);
      tick = 1'b1;
      step();
      tick = 1'b0;
      chk({tag, " after tick"}, pullLow, (t < n) ? 1 : 0);
    end
  endtask

  task automatic setShort(input bit v);
    cfgWr = 1'b1; cfgShort = v;
    step();
    cfgWr = 1'b0;
    chk("R4 short bit write", shortLenQ, v);
  endtask

  task automatic clearStatus();
    rdClr = 1'b1;
    step();
    rdClr = 1'b0;
    chk("R10 code cleared", statusCode, 0);
    chk("R10 por flag cleared", porFlag, 0);
  endtask

  function automatic int lowestCode(input logic [NUM_REQ-1:0] m);
    for (int k = 0; k < NUM_REQ; k++) if (m[k]) return k + 2;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 pullLow", pullLow, 0);
    chk("R1 code", statusCode, 0);
    chk("R1 porFlag", porFlag, 0);
    chk("R1 shortLenQ", shortLenQ, 0);
    rstN = 1'b1;
    step();

    // R4 write both values
    setShort(1'b1);
    setShort(1'b0);

    // R2 / R8: each source alone, long pulse
    for (int k = 0; k < NUM_REQ; k++) begin
      srcReq[k] = 1'b1;
      step();
      srcReq = '0;
      chk("R2 start", pullLow, 1);
      chk("R8 single code", statusCode, k + 2);
      chk("R11 active in pulse", resetActive, 1);
      runPulse(LONG_N, "R2 long");
      chk("R11 idle", resetActive, 0);
      clearStatus();
    end

    // R3 / R8: every mix of simultaneous requests, short pulse
    setShort(1'b1);
    for (int m = 1; m < (1 << NUM_REQ); m++) begin
      srcReq = NUM_REQ'(m);
      step();
      srcReq = '0;
      chk("R8 priority code", statusCode, lowestCode(NUM_REQ'(m)));
      runPulse(SHORT_N, "R3 short");
    end
    setShort(1'b0);

    // R9: request during a pulse changes nothing
    srcReq[5] = 1'b1;
    step();
    srcReq = '0;
    for (int t = 0; t < 2; t++) begin
      tick = 1'b1; step(); tick = 1'b0;
      chk("R9 still held", pullLow, 1);
    end
    srcReq[0] = 1'b1;
    step();
    srcReq = '0;
    chk("R9 code unchanged", statusCode, 7);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R9 no restart", pullLow, 1);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R9 released on original count", pullLow, 0);

    // R10: capture wins over clear in same cycle; status held otherwise
    repeat (3) step();
    chk("R10 held", statusCode, 7);
    rdClr = 1'b1; srcReq[3] = 1'b1;
    step();
    rdClr = 1'b0; srcReq = '0;
    chk("R10 capture wins", statusCode, 5);
    runPulse(LONG_N, "R10 pulse");
    clearStatus();

    // R6 / R11: outside falling edge overrides short setting
    setShort(1'b1);
    extLow = 1'b1;
    #1;
    chk("R11 pad low, not pulling", resetActive, 1);
    chk("R11 pullLow idle", pullLow, 0);
    step();
    extLow = 1'b0;
    chk("R6 start", pullLow, 1);
    chk("R6 code", statusCode, 1);
    chk("R6 porFlag untouched", porFlag, 0);
    chk("R6 short cleared", shortLenQ, 0);
    runPulse(LONG_N, "R6 long");
    clearStatus();

    // R7: restart entry reverts to long
    setShort(1'b1);
    restartEntry = 1'b1;
    step();
    restartEntry = 1'b0;
    chk("R7 short cleared", shortLenQ, 0);
    srcReq[1] = 1'b1;
    step();
    srcReq = '0;
    runPulse(LONG_N, "R7 long");
    clearStatus();

    // R5: power-on holds the line, then long pulse
    setShort(1'b1);
    porActive = 1'b1;
    for (int t = 0; t < 6; t++) begin
      tick = t[0];
      step();
      chk("R5 held during power-on", pullLow, 1);
    end
    tick = 1'b0;
    porActive = 1'b0;
    chk("R5 porFlag", porFlag, 1);
    chk("R5 code", statusCode, 1);
    chk("R5 short cleared", shortLenQ, 0);
    runPulse(LONG_N, "R5 long");
    clearStatus();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule